// File: doc/BRIEF.md
# Hang Recovery Watchdog

This block protects a system against a lockup caused by a bad clock-frequency setting. Software loads a timeout in units of one quarter second and then arms the watchdog. If software does not disarm or re-arm it before the count runs out, the block starts recovery. It drives an active-low system reset for a fixed length of time, sets a sticky timeout flag and raises a one-cycle request. That request tells the frequency logic to reload its fallback selection and to drop any direct divisor programming.

The quarter-second tick comes from a prescaler on the system clock. `TICK_DIV` sets how many clocks make one unit, so a bench can use a short unit. Three read-back values are exported:
- a running bit, which shows whether the count is live, not what was last written;
- the timeout flag;
- the count, which while running is the remaining number of units and otherwise is the programmed value.

The reset output is a level for an open-drain pad: 0 means pull low.

Top module: `hang_watchdog`

## Requirements
- R1: After synchronous reset, `run_rd`=0, `tmo_rd`=0, `cnt_rd`=`DEF_COUNT` (8), `sys_rst_n`=1 and `fallback_req`=0.
- R2: While idle, a count write (`cnt_we`=1) stores `cnt_wd`. `cnt_rd` shows the stored value from the next cycle, and nothing starts.
- R3: An arm write (`arm_we`=1, `arm_wd`=1) starts the count. From the next cycle `run_rd`=1, `tmo_rd`=0, and k cycles after the arm `cnt_rd` = N − floor(k/`TICK_DIV`).
- R4: With a programmed count N≥1, the watchdog expires exactly N·`TICK_DIV` cycles after the arm. With N=0 it expires after `TICK_DIV` cycles. At expiry `run_rd` falls to 0 and `tmo_rd` rises to 1.
- R5: `sys_rst_n` goes low in the expiry cycle and stays low for exactly `PULSE_UNITS`·`TICK_DIV` cycles.
- R6: `fallback_req` is 1 for exactly one cycle, the expiry cycle, and is otherwise 0.
- R7: A disarm write (`arm_we`=1, `arm_wd`=0) stops the count at once. After it there is no expiry, no reset pulse, `tmo_rd` keeps its value and `cnt_rd` returns the programmed value.
- R8: A count write or an arm write while running reloads the counter with the programmed value and restarts the prescaler, so expiry moves to N·`TICK_DIV` cycles after that write.
- R9: Arming after a timeout clears `tmo_rd`. `tmo_rd` and `run_rd` are never both 1. After expiry `cnt_rd` returns the programmed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_we | input | 1 | Enable write strobe |
| arm_wd | input | 1 | Enable write data: 1 arms, 0 disarms |
| cnt_we | input | 1 | Count write strobe |
| cnt_wd | input | CNT_W | Count write data in quarter-second units |
| run_rd | output | 1 | 1 while the count is running |
| tmo_rd | output | 1 | Sticky timeout flag |
| cnt_rd | output | CNT_W | Remaining count while running, else the programmed count |
| sys_rst_n | output | 1 | Active-low reset level for an open-drain pad |
| fallback_req | output | 1 | One-cycle request for frequency fallback and divisor-programming clear |

## Verification
The hardest situations to reach are a reload that lands in the middle of a count, after the prescaler has partly advanced, and the zero count, which must behave like a count of one. The bench sweeps every count from 0 to 12, plus 255, on a four-clock unit. For each count it predicts the running bit, the remaining count, the flag, the request and the reset level on every cycle from the arm until the pulse ends. It then reloads mid-unit by a count write and by a second arm, and checks that expiry moves to the new full window. It disarms in mid-count and checks that the outputs stay quiet.

// File: rtl/hwd_pkg.sv
package hwd_pkg;
  typedef enum logic [1:0] {
    HWD_IDLE_OP = 2'd0,
    HWD_START   = 2'd1,
    HWD_STOP    = 2'd2,
    HWD_STORE   = 2'd3
  } hwd_op_e;

  function automatic hwd_op_e hwd_decode(input logic arm_we, input logic arm_wd,
                                          input logic cnt_we, input logic running);
    if (arm_we && !arm_wd)            return HWD_STOP;
    else if (arm_we && arm_wd)        return HWD_START;
    else if (cnt_we && running)       return HWD_START;
    else if (cnt_we)                  return HWD_STORE;
    else                              return HWD_IDLE_OP;
  endfunction
endpackage

// File: rtl/hwd_prescale.sv
module hwd_prescale #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || restart || !run) div_q <= '0;
    else if (div_q == LAST)     div_q <= '0;
    else                        div_q <= div_q + PW'(1);
  end

  assign tick = run && (div_q == LAST);

  a_r4_presc_range: assert property (@(posedge clk) disable iff (rst)
    div_q <= LAST);
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (div_q == '0));
endmodule

// File: rtl/hwd_downcount.sv
module hwd_downcount
  import hwd_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DEF_COUNT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_we,
  input  logic             arm_wd,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wd,
  input  logic             tick,
  output logic             restart,
  output logic             run,
  output logic             expired,
  output logic             expire_now,
  output logic             expire_evt,
  output logic [CNT_W-1:0] live
);
  hwd_op_e          op;
  logic             run_q, tmo_q, evt_q;
  logic [CNT_W-1:0] prog_q, live_q, new_prog;

  assign op         = hwd_decode(arm_we, arm_wd, cnt_we, run_q);
  assign new_prog   = cnt_we ? cnt_wd : prog_q;
  assign restart    = (op == HWD_START);
  assign expire_now = run_q && tick && (live_q <= CNT_W'(1)) && (op == HWD_IDLE_OP);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      tmo_q  <= 1'b0;
      evt_q  <= 1'b0;
      prog_q <= CNT_W'(DEF_COUNT);
      live_q <= CNT_W'(DEF_COUNT);
    end else begin
      evt_q <= 1'b0;
      if (cnt_we) prog_q <= cnt_wd;
      unique case (op)
        HWD_STOP: begin
          run_q  <= 1'b0;
          live_q <= new_prog;
        end
        HWD_START: begin
          run_q  <= 1'b1;
          tmo_q  <= 1'b0;
          live_q <= new_prog;
        end
        HWD_STORE: live_q <= cnt_wd;
        default: begin
          if (expire_now) begin
            run_q  <= 1'b0;
            tmo_q  <= 1'b1;
            evt_q  <= 1'b1;
            live_q <= prog_q;
          end else if (run_q && tick) begin
            live_q <= live_q - CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign run        = run_q;
  assign expired    = tmo_q;
  assign expire_evt = evt_q;
  assign live       = live_q;

  a_r9_flag_excl: assert property (@(posedge clk) disable iff (rst)
    !(run_q && tmo_q));
  a_r3_live_bound: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (live_q <= prog_q));
  a_r6_evt_single: assert property (@(posedge clk) disable iff (rst)
    evt_q |=> !evt_q);
  a_r7_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    (arm_we && !arm_wd) |=> (!run_q && $stable(tmo_q)));
  a_r9_start_clears: assert property (@(posedge clk) disable iff (rst)
    (arm_we && arm_wd) |=> (run_q && !tmo_q));
endmodule

// File: rtl/hwd_pulse.sv
module hwd_pulse #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic rst_n_o
);
  localparam int W = $clog2(PULSE_CYC + 1);

  logic [W-1:0] left_q;
  logic         low_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      low_q  <= 1'b0;
    end else if (fire) begin
      low_q  <= 1'b1;
      left_q <= W'(PULSE_CYC - 1);
    end else if (left_q != '0) begin
      left_q <= left_q - W'(1);
    end else begin
      low_q  <= 1'b0;
    end
  end

  assign rst_n_o = !low_q;

  a_r5_low_on_fire: assert property (@(posedge clk) disable iff (rst)
    fire |=> low_q);
  a_r5_left_bound: assert property (@(posedge clk) disable iff (rst)
    left_q <= W'(PULSE_CYC - 1));
  a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
    (!low_q && !fire) |=> !low_q);
endmodule

// File: rtl/hang_watchdog.sv
module hang_watchdog #(
  parameter int CNT_W       = 8,
  parameter int DEF_COUNT   = 8,
  parameter int TICK_DIV    = 31_250_000,
  parameter int PULSE_UNITS = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_we,
  input  logic             arm_wd,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wd,
  output logic             run_rd,
  output logic             tmo_rd,
  output logic [CNT_W-1:0] cnt_rd,
  output logic             sys_rst_n,
  output logic             fallback_req
);
  localparam int PULSE_CYC = PULSE_UNITS * TICK_DIV;

  logic tick, restart, run, expire_now;

  hwd_prescale #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst(rst), .restart(restart), .run(run), .tick(tick)
  );

  hwd_downcount #(.CNT_W(CNT_W), .DEF_COUNT(DEF_COUNT)) u_cnt (
    .clk(clk), .rst(rst), .arm_we(arm_we), .arm_wd(arm_wd),
    .cnt_we(cnt_we), .cnt_wd(cnt_wd), .tick(tick), .restart(restart),
    .run(run), .expired(tmo_rd), .expire_now(expire_now),
    .expire_evt(fallback_req), .live(cnt_rd)
  );

  hwd_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst(rst), .fire(expire_now), .rst_n_o(sys_rst_n)
  );

  assign run_rd = run;

  a_r6_fallback_in_pulse: assert property (@(posedge clk) disable iff (rst)
    fallback_req |-> !sys_rst_n);
  a_r4_expiry_sets_flag: assert property (@(posedge clk) disable iff (rst)
    fallback_req |-> (tmo_rd && !run_rd));
endmodule

// File: tb/hang_watchdog_test.sv
module hang_watchdog_test;
  localparam int DIV = 4;
  localparam int PU  = 2;
  localparam int P   = PU * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       arm_we = 1'b0, arm_wd = 1'b0, cnt_we = 1'b0;
  logic [7:0] cnt_wd = '0;
  logic       run_rd, tmo_rd, sys_rst_n, fallback_req;
  logic [7:0] cnt_rd;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  hang_watchdog #(.CNT_W(8), .DEF_COUNT(8), .TICK_DIV(DIV), .PULSE_UNITS(PU)) uut (
    .clk(clk), .rst(rst), .arm_we(arm_we), .arm_wd(arm_wd), .cnt_we(cnt_we),
    .cnt_wd(cnt_wd), .run_rd(run_rd), .tmo_rd(tmo_rd), .cnt_rd(cnt_rd),
    .sys_rst_n(sys_rst_n), .fallback_req(fallback_req)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_cnt(input int v);
    @(negedge clk); cnt_we = 1'b1; cnt_wd = 8'(v);
    @(negedge clk); cnt_we = 1'b0;
  endtask

  task automatic wr_arm(input bit v);
    @(negedge clk); arm_we = 1'b1; arm_wd = v;
    @(negedge clk); arm_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Follow one full window from an arm (k=0 sample) until the pulse ends.
  task automatic follow(input int n, input string req);
    int e;
    e = ((n == 0) ? 1 : n) * DIV;
    for (int k = 1; k <= e + P + 1; k++) begin
      @(negedge clk);
      check({req, " R4 run"}, run_rd, (k < e) ? 1 : 0);
      check({req, " R4 flag"}, tmo_rd, (k >= e) ? 1 : 0);
      check({req, " R3 count"}, cnt_rd, (k < e) ? n - k / DIV : n);
      check({req, " R6 fallback"}, fallback_req, (k == e) ? 1 : 0);
      check({req, " R5 reset_n"}, sys_rst_n, (k >= e && k < e + P) ? 0 : 1);
    end
  endtask

  initial begin
    wait_cyc(3);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 run", run_rd, 0);
    check("R1 flag", tmo_rd, 0);
    check("R1 count", cnt_rd, 8);
    check("R1 reset_n", sys_rst_n, 1);
    check("R1 fallback", fallback_req, 0);

    // Sweep of counts: R2, R3, R4, R5, R6, R9
    for (int n = 0; n <= 13; n++) begin
      int nv;
      nv = (n == 13) ? 255 : n;
      wr_cnt(nv);
      check("R2 stored", cnt_rd, nv);
      check("R2 no start", run_rd, 0);
      wr_arm(1'b1);
      check("R3 running", run_rd, 1);
      check("R9 flag cleared", tmo_rd, 0);
      check("R3 count k0", cnt_rd, nv);
      follow(nv, "sweep");
      check("R9 count after expiry", cnt_rd, nv);
    end

    // R7: disarm mid-count
    wr_cnt(3);
    wr_arm(1'b1);
    wait_cyc(5);
    wr_arm(1'b0);
    check("R7 stopped", run_rd, 0);
    check("R7 flag kept", tmo_rd, 0);
    check("R7 count", cnt_rd, 3);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R7 no fallback", fallback_req, 0);
      check("R7 no reset", sys_rst_n, 1);
      check("R7 idle", run_rd, 0);
    end

    // R8: count write while running reloads mid-unit
    wr_cnt(2);
    wr_arm(1'b1);
    wait_cyc(5);
    check("R8 before reload", cnt_rd, 1);
    wr_cnt(5);
    check("R8 reload count", cnt_rd, 5);
    check("R8 still running", run_rd, 1);
    follow(5, "R8 cnt-reload");

    // R8: second arm while running reloads
    wr_cnt(2);
    wr_arm(1'b1);
    wait_cyc(6);
    wr_arm(1'b1);
    check("R8 rearm count", cnt_rd, 2);
    follow(2, "R8 arm-reload");

    // R9: re-arm after timeout clears flag
    check("R9 flag set", tmo_rd, 1);
    wr_arm(1'b1);
    check("R9 flag clear", tmo_rd, 0);
    check("R9 running", run_rd, 1);
    wr_arm(1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule